// File: doc/BRIEF.md
# Banked Logical-to-Physical Address Translator

This block maps a 16-bit CPU logical address onto a 20-bit physical address. The logical space is divided, at 4 KB steps, into up to three consecutive areas: a low fixed area that passes straight through, a middle bank area, and a high common area. The bank area and the high common area each have their own 8-bit base. That base is placed at 4 KB granularity and added to the logical address, so each of those two areas can sit anywhere in the 1 MB physical space.

Three 8-bit registers control the mapping. The boundary register holds two nibbles. The low nibble is the page where the bank area begins, and the high nibble is the page where the high common area begins. The other two registers are the bank base and the high common base. Software writes and reads the registers through a small I/O port interface, and each register has its own port address set by a parameter. The translation is purely combinational, so the physical address follows the logical address in the same cycle. The registers are clocked and have a synchronous active-low reset.

Top module: `bank_xlat`

## Requirements
- R1: After reset, the boundary register reads 0xF0, both base registers read 0x00, and `cfg_err` is 0.
- R2: With the reset settings, every logical address maps to itself zero-extended to 20 bits (for example 0x1000 maps to 0x01000 and 0xF800 maps to 0x0F800).
- R3: The area is chosen by priority on logical bits [15:12], which form the page. A page at or above the high nibble of the boundary register (bits [7:4]) selects the high common area. Otherwise, a page at or above the low nibble (bits [3:0]) selects the bank area. Otherwise the low fixed area is selected.
- R4: In the low fixed area, the physical address equals the logical address, with physical bits [19:16] zero.
- R5: In the bank area, the physical address is the logical address plus the bank base times 4096.
- R6: In the high common area, the physical address is the logical address plus the high common base times 4096.
- R7: The 20-bit sum wraps modulo 2^20, and the carry out of bit 19 is discarded.
- R8: An I/O write to a register port (boundary at P_BOUND, default 0x3A; bank base at P_BANK, default 0x39; high common base at P_COMMON, default 0x38) updates that register on the next clock edge. `io_rdata` returns the value of the addressed register. A write to any other port address has no effect, and reads of other addresses return 0.
- R9: A boundary write whose high nibble is less than its low nibble is stored unchanged and sets the sticky flag `cfg_err`. Only reset clears the flag. Translation still follows the priority rule of R3.
- R10: The degenerate layouts translate correctly. With both nibbles 0, the whole space is high common. With only the low nibble 0, there is no low fixed area. With both nibbles equal and nonzero, there is no bank area.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Value of the addressed register |
| log_addr | input | 16 | Logical address |
| phys_addr | output | 20 | Translated physical address |
| cfg_err | output | 1 | Sticky flag for a boundary write with its nibbles in the wrong order |

## Verification
The hardest state to reach is a boundary register that holds its nibbles in the wrong order. Software should never write it, so the block only reaches it through a deliberate illegal write. Once there, the priority rule has to hide the bank area completely. The bench reaches this state on purpose: it writes a boundary value with its high nibble below its low nibble, then probes pages on both sides of each nibble, and confirms the flag stays set after a later legal write. The wrap case needs a base large enough to push the sum past 1 MB, so the bench loads bases near 0xFF.

// File: rtl/bx_pkg.sv
// Shared types for the banked address translator.
package bx_pkg;
    // Which logical area an address falls into.
    typedef enum logic [1:0] {
        AREA_C0   = 2'd0,
        AREA_BANK = 2'd1,
        AREA_C1   = 2'd2
    } area_e;
endpackage

// File: rtl/bx_regfile.sv
// Control register file: boundary register, two base registers and the
// sticky ordering-error flag. Assumes single-cycle write strobes; reads are
// combinational from io_addr. Unmatched port addresses read as zero.
module bx_regfile #(
    parameter int          IO_AW     = 8,
    parameter int          REG_W     = 8,
    parameter int          PAGE_W    = 4,
    parameter logic [7:0]  P_BOUND   = 8'h3A,
    parameter logic [7:0]  P_BANK    = 8'h39,
    parameter logic [7:0]  P_COMMON  = 8'h38,
    parameter logic [7:0]  BOUND_RST = 8'hF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [REG_W-1:0] io_wdata,
    output logic [REG_W-1:0] io_rdata,
    output logic [REG_W-1:0] bound_q,
    output logic [REG_W-1:0] bank_q,
    output logic [REG_W-1:0] com_q,
    output logic             cfg_err
);
    localparam logic [IO_AW-1:0] A_BOUND  = IO_AW'(P_BOUND);
    localparam logic [IO_AW-1:0] A_BANK   = IO_AW'(P_BANK);
    localparam logic [IO_AW-1:0] A_COMMON = IO_AW'(P_COMMON);

    logic wr_bound, wr_bank, wr_com, bad_order;

    // Decode which register a write targets and whether it misorders nibbles.
    always_comb begin
        wr_bound  = io_wr && (io_addr == A_BOUND);
        wr_bank   = io_wr && (io_addr == A_BANK);
        wr_com    = io_wr && (io_addr == A_COMMON);
        bad_order = io_wdata[2*PAGE_W-1:PAGE_W] < io_wdata[PAGE_W-1:0];
    end

    // Register updates with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bound_q <= REG_W'(BOUND_RST);
            bank_q  <= '0;
            com_q   <= '0;
            cfg_err <= 1'b0;
        end else begin
            if (wr_bound) bound_q <= io_wdata;
            if (wr_bank)  bank_q  <= io_wdata;
            if (wr_com)   com_q   <= io_wdata;
            if (wr_bound && bad_order) cfg_err <= 1'b1;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        if (io_addr == A_BOUND)       io_rdata = bound_q;
        else if (io_addr == A_BANK)   io_rdata = bank_q;
        else if (io_addr == A_COMMON) io_rdata = com_q;
        else                          io_rdata = '0;
    end
endmodule

// File: rtl/bx_area_sel.sv
// Area selector: classifies a logical page against the two boundary nibbles
// by priority (high common first, then bank, else low fixed). Assumes nothing
// about nibble ordering; a misordered pair simply hides the bank area.
module bx_area_sel #(
    parameter int PAGE_W = 4
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [PAGE_W-1:0] ba,
    input  logic [PAGE_W-1:0] ca,
    output bx_pkg::area_e     area
);
    // Priority compare of the page against the boundaries.
    always_comb begin
        if (page >= ca)      area = bx_pkg::AREA_C1;
        else if (page >= ba) area = bx_pkg::AREA_BANK;
        else                 area = bx_pkg::AREA_C0;
    end
endmodule

// File: rtl/bx_adder.sv
// Physical address former: picks the base for the selected area (zero for
// the low fixed area), shifts it to page granularity and adds it to the
// zero-extended logical address. Assumes OFF_W + BASE_W == PA_W; the
// sum wraps within PA_W bits.
module bx_adder #(
    parameter int LA_W   = 16,
    parameter int PA_W   = 20,
    parameter int BASE_W = 8,
    parameter int OFF_W  = 12
) (
    input  logic [LA_W-1:0]   log_addr,
    input  bx_pkg::area_e     area,
    input  logic [BASE_W-1:0] bank_base,
    input  logic [BASE_W-1:0] com_base,
    output logic [PA_W-1:0]   phys_addr
);
    logic [BASE_W-1:0] sel_base;
    logic [PA_W-1:0]   base_sh;
    logic [PA_W-1:0]   log_ext;

    // Select the base that applies to the current area.
    always_comb begin
        case (area)
            bx_pkg::AREA_BANK: sel_base = bank_base;
            bx_pkg::AREA_C1:   sel_base = com_base;
            default:           sel_base = '0;
        endcase
    end

    // Align base to page granularity and add with modulo-2^PA_W wrap.
    always_comb begin
        base_sh   = PA_W'({sel_base, {OFF_W{1'b0}}});
        log_ext   = PA_W'(log_addr);
        phys_addr = log_ext + base_sh;
    end
endmodule

// File: rtl/bank_xlat.sv
// Top of the banked logical-to-physical translator. Holds the control
// registers and drives a combinational translation path. Assumes a
// 16-bit logical space, page nibble = top PAGE_W logical bits.
module bank_xlat #(
    parameter int         LA_W     = 16,
    parameter int         PA_W     = 20,
    parameter int         PAGE_W   = 4,
    parameter int         IO_AW    = 8,
    parameter logic [7:0] P_BOUND  = 8'h3A,
    parameter logic [7:0] P_BANK   = 8'h39,
    parameter logic [7:0] P_COMMON = 8'h38
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    input  logic [LA_W-1:0]  log_addr,
    output logic [PA_W-1:0]  phys_addr,
    output logic             cfg_err
);
    localparam int OFF_W  = LA_W - PAGE_W;
    localparam int BASE_W = PA_W - OFF_W;
    localparam int REG_W  = 2 * PAGE_W;

    logic [REG_W-1:0]  bound_q;
    logic [BASE_W-1:0] bank_q;
    logic [BASE_W-1:0] com_q;
    bx_pkg::area_e     area;

    bx_regfile #(
        .IO_AW(IO_AW), .REG_W(REG_W), .PAGE_W(PAGE_W),
        .P_BOUND(P_BOUND), .P_BANK(P_BANK), .P_COMMON(P_COMMON),
        .BOUND_RST(8'hF0)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .bound_q(bound_q),
        .bank_q(bank_q), .com_q(com_q), .cfg_err(cfg_err)
    );

    bx_area_sel #(.PAGE_W(PAGE_W)) u_sel (
        .page(log_addr[LA_W-1:OFF_W]),
        .ba(bound_q[PAGE_W-1:0]),
        .ca(bound_q[REG_W-1:PAGE_W]),
        .area(area)
    );

    bx_adder #(
        .LA_W(LA_W), .PA_W(PA_W), .BASE_W(BASE_W), .OFF_W(OFF_W)
    ) u_add (
        .log_addr(log_addr), .area(area), .bank_base(bank_q),
        .com_base(com_q), .phys_addr(phys_addr)
    );
endmodule

// File: rtl/bank_xlat_chk.sv
// Property checker for bank_xlat, attached by bind. Observes ports plus the
// register outputs of the register file.
module bank_xlat_chk #(
    parameter int         LA_W     = 16,
    parameter int         PA_W     = 20,
    parameter int         PAGE_W   = 4,
    parameter int         IO_AW    = 8,
    parameter logic [7:0] P_BOUND  = 8'h3A,
    parameter logic [7:0] P_BANK   = 8'h39
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_wr,
    input logic [IO_AW-1:0] io_addr,
    input logic [7:0]       io_wdata,
    input logic [LA_W-1:0]  log_addr,
    input logic [PA_W-1:0]  phys_addr,
    input logic             cfg_err,
    input logic [7:0]       bound_q,
    input logic [7:0]       bank_q,
    input logic [7:0]       com_q
);
    localparam int OFF_W = LA_W - PAGE_W;
    localparam int BASE_W = PA_W - OFF_W;

    logic [PAGE_W-1:0] page, ba, ca;
    logic [BASE_W-1:0] hi_exp;
    assign page   = log_addr[LA_W-1:OFF_W];
    assign ba     = bound_q[PAGE_W-1:0];
    assign ca     = bound_q[2*PAGE_W-1:PAGE_W];
    assign hi_exp = BASE_W'(page) + com_q;

    // First cycle out of reset shows the reset register values.
    assert_reset_vals_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (bound_q == 8'hF0 && bank_q == 8'h00 &&
                          com_q == 8'h00 && !cfg_err));

    // Low fixed area passes through.
    assert_c0_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (page < ba && page < ca) |-> (phys_addr == PA_W'(log_addr)));

    // High common area: offset kept, page field offset by the base.
    assert_c1_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (page >= ca) |-> (phys_addr[OFF_W-1:0] == log_addr[OFF_W-1:0] &&
                          phys_addr[PA_W-1:OFF_W] == hi_exp));

    // A bank-base write lands on the next edge.
    assert_bank_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == IO_AW'(P_BANK)) |=> (bank_q == $past(io_wdata)));

    // A misordered boundary write raises the flag.
    assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == IO_AW'(P_BOUND) && io_wdata[7:4] < io_wdata[3:0])
        |=> cfg_err);

    // The flag is sticky until reset.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

bind bank_xlat bank_xlat_chk #(
    .LA_W(LA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .IO_AW(IO_AW),
    .P_BOUND(P_BOUND), .P_BANK(P_BANK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .log_addr(log_addr), .phys_addr(phys_addr),
    .cfg_err(cfg_err), .bound_q(bound_q), .bank_q(bank_q), .com_q(com_q)
);

// File: tb/bank_xlat_test.sv
// Directed bench for bank_xlat: one task per scenario, each self-checking.
module bank_xlat_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = 8'h00;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [15:0] log_addr = 16'h0000;
    logic [19:0] phys_addr;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] PB = 8'h3A;
    localparam logic [7:0] PK = 8'h39;
    localparam logic [7:0] PC = 8'h38;

    bank_xlat uut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .log_addr(log_addr),
        .phys_addr(phys_addr), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp,
                          input string what);
        io_addr = a;
        #1;
        check(32'(io_rdata), 32'(exp), what);
    endtask

    task automatic xl_chk(input logic [15:0] la, input logic [19:0] exp,
                          input string what);
        log_addr = la;
        #1;
        check(32'(phys_addr), 32'(exp), what);
    endtask

    task automatic t_reset;
        rd_chk(PB, 8'hF0, "R1 boundary reset");
        rd_chk(PK, 8'h00, "R1 bank base reset");
        rd_chk(PC, 8'h00, "R1 common base reset");
        check(32'(cfg_err), 32'd0, "R1 flag reset");
    endtask

    task automatic t_identity;
        xl_chk(16'h1000, 20'h01000, "R2 identity 0x1000");
        xl_chk(16'hF800, 20'h0F800, "R2 identity 0xF800");
        xl_chk(16'h0000, 20'h00000, "R2 identity 0x0000");
    endtask

    task automatic t_three_areas;
        io_write(PB, 8'hC8);
        io_write(PK, 8'h10);
        io_write(PC, 8'h40);
        xl_chk(16'h2345, 20'h02345, "R4 low area pass");
        xl_chk(16'h7FFF, 20'h07FFF, "R3 page below bank start");
        xl_chk(16'h8000, 20'h18000, "R5 bank first page");
        xl_chk(16'hBFFF, 20'h1BFFF, "R5 bank last byte");
        xl_chk(16'hC000, 20'h4C000, "R6 high common first page");
        xl_chk(16'hFFFF, 20'h4FFFF, "R6 high common top");
    endtask

    task automatic t_wrap;
        io_write(PC, 8'hFF);
        xl_chk(16'hF123, 20'h0E123, "R7 high common wrap");
        io_write(PK, 8'hF8);
        xl_chk(16'h9000, 20'h01000, "R7 bank wrap");
    endtask

    task automatic t_layouts;
        io_write(PC, 8'h05);
        io_write(PK, 8'h10);
        io_write(PB, 8'h00);
        xl_chk(16'h0000, 20'h05000, "R10 all high common low end");
        xl_chk(16'h7ABC, 20'h0CABC, "R10 all high common mid");
        io_write(PB, 8'h80);
        xl_chk(16'h0100, 20'h10100, "R10 bank from zero");
        xl_chk(16'h8000, 20'h0D000, "R10 high common above bank");
        io_write(PB, 8'h55);
        xl_chk(16'h4FFF, 20'h04FFF, "R10 no bank low side");
        xl_chk(16'h5000, 20'h0A000, "R10 no bank high side");
    endtask

    task automatic t_ports;
        io_write(8'h00, 8'hAA);
        io_write(8'h3B, 8'hAA);
        rd_chk(PB, 8'h55, "R8 boundary unchanged");
        rd_chk(PK, 8'h10, "R8 bank unchanged");
        rd_chk(PC, 8'h05, "R8 common unchanged");
        rd_chk(8'h3B, 8'h00, "R8 unmapped read zero");
        check(32'(cfg_err), 32'd0, "R8 flag unchanged");
    endtask

    task automatic t_bad_order;
        io_write(PB, 8'h3A);
        check(32'(cfg_err), 32'd1, "R9 flag set");
        rd_chk(PB, 8'h3A, "R9 value stored");
        xl_chk(16'h2000, 20'h02000, "R9 below both nibbles");
        xl_chk(16'h4000, 20'h09000, "R9 page between nibbles is high common");
        xl_chk(16'hB000, 20'h10000, "R9 page above both nibbles");
        io_write(PB, 8'hC8);
        check(32'(cfg_err), 32'd1, "R9 flag sticky");
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_three_areas();
        t_wrap();
        t_layouts();
        t_ports();
        t_bad_order();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule